// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port (Slave)

This block connects a 24-bit stereo sample core to a serial audio link whose bit clock and frame (left/right) clock are driven by an external master. One serial input carries playback samples toward the core, and one serial output carries capture samples away from it. Four framings are selectable: I2S, left-justified, right-justified and a DSP framing with a frame pulse. Four wire word lengths are also selectable. On both paths the block converts between the fixed 24-bit core width and the wire length.

The external clocks are oversampled by the block's own `clk`. Inputs are sampled on the bit-clock rising edge, and the output changes on the falling edge. The core side is a stream in each direction.

The transmit side accepts one stereo pair through `tx_valid`/`tx_ready`. `tx_ready` is high while the single pair buffer is empty. The buffered pair is taken at the start of each left slot. If no pair is waiting at that point, zeros are sent for that frame.

The receive side cannot stall the wire. `rx_valid` rises when a right word completes and stays high until `rx_ready` is seen. A later pair overwrites an unread one.

Top module: `aud_serial_port`

## Requirements
- R1: While `en` is 0 the block is idle: `sdout_oe` is 0, `sdout` is 0, `tx_ready` is 0 and `rx_valid` is 0. Any buffered pair is discarded. One cycle after `en` rises, `sdout_oe` is 1.
- R2: The wire word length W is set by `wlen`: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. When `fmt` is 2 (right-justified) and `wlen` is 3, W is 24.
- R3: When `fmt` is 0 (I2S), frame clock low is the left half and high is the right half. The word MSB is on the second bit clock of each half.
- R4: When `fmt` is 1 (left-justified), frame clock high is the left half and low is the right half. The word MSB is on the first bit clock of each half.
- R5: When `fmt` is 2 (right-justified), the halves are as in R4. The word LSB is on the last bit clock of each half, using the length of the preceding half. The first half after enable carries no word.
- R6: When `fmt` is 3 (DSP), a frame begins on the first bit clock that sees the frame clock high. The left MSB is on bit clock 1 of the frame when `dsp_late` is 0, or on bit clock 2 when it is 1. The right word follows the left LSB immediately.
- R7: Transmit sends MSB first. For W below 24 the word is the top W bits of the sample. For W of 32 the 24 sample bits are followed by 8 zero bits. Every bit clock outside a word drives 0.
- R8: Receive takes MSB first. For W below 24 the received bits are placed at the top and the low bits are zero. For W of 32 the first 24 bits are kept and the last 8 are dropped. Bits outside a word are ignored.
- R9: `rx_valid` rises after the right word of a frame completes and presents the left and right words of that frame. It stays high until a cycle with `rx_ready` high, and falls after that cycle.
- R10: `tx_ready` is high while `en` is 1 and the pair buffer is empty, and falls after a cycle with `tx_valid` high. The buffered pair is used for the frame that starts next. A frame that starts with the buffer empty transmits zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| wlen | input | 2 | Wire word length code (R2) |
| dsp_late | input | 1 | DSP framing: MSB on the second bit clock of the frame |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock |
| sdin | input | 1 | Serial playback data in |
| sdout | output | 1 | Serial capture data out |
| sdout_oe | output | 1 | Output enable for the `sdout` pad (0 = high impedance) |
| tx_valid | input | 1 | Core offers a stereo pair to send |
| tx_ready | output | 1 | Pair buffer is empty |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Core takes the received pair |
| rx_left | output | 24 | Received left sample |
| rx_right | output | 24 | Received right sample |

## Verification
The hardest case to reach is the right-justified framing. Its word position depends on the length of the half-frame before it, so it can only be checked after the port has seen a full half-frame since enable.

The longest word in I2S needs a half-frame longer than 32 bit clocks. The stimulus therefore re-enables the port for every framing, word length and DSP offset. It then runs four back-to-back frames of 40 bit clocks per half, and the first frame serves only as warm-up.

The zero-fill of R10 is reached by offering no pair before the fourth frame. Unused slots are driven with ones on `sdin`, which shows that the receiver ignores them.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;
  parameter int SAMPLE_W = 24;
  parameter int MAX_WORD = 32;
  parameter int CNT_W    = 7;
  parameter int POS_W    = $clog2(MAX_WORD) + 1;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             active;
    logic             right;
    logic [POS_W-1:0] pos;
  } slot_t;

  // Effective wire word length for a format and length code.
  function automatic logic [POS_W-1:0] word_bits(fmt_e f, logic [1:0] wl);
    logic [POS_W-1:0] w;
    case (wl)
      2'd0:    w = POS_W'(16);
      2'd1:    w = POS_W'(20);
      2'd2:    w = POS_W'(24);
      default: w = (f == FMT_RJ) ? POS_W'(24) : POS_W'(MAX_WORD);
    endcase
    return w;
  endfunction

  // Map a bit-clock index (and half length) onto channel and word position.
  function automatic slot_t slot_decode(fmt_e f, logic [POS_W-1:0] w, logic late,
                                        logic lr, logic [CNT_W-1:0] cnt,
                                        logic [CNT_W-1:0] hlen);
    slot_t            s;
    logic [CNT_W-1:0] wc;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] rel;
    logic             ok;
    wc    = CNT_W'(w);
    s     = '0;
    start = '0;
    ok    = 1'b1;
    case (f)
      FMT_I2S: begin start = CNT_W'(1); s.right = lr; end
      FMT_LJ:  begin start = '0;        s.right = ~lr; end
      FMT_RJ:  begin start = hlen - wc; s.right = ~lr; ok = (hlen >= wc); end
      default: begin start = late ? CNT_W'(1) : '0; s.right = (cnt >= start + wc); end
    endcase
    rel = cnt - start;
    if (f == FMT_DSP) begin
      s.active = (cnt >= start) && (rel < (wc << 1));
      if (s.right) rel = rel - wc;
    end else begin
      s.active = ok && (cnt >= start) && (rel < wc);
    end
    s.pos = rel[POS_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdin_i,
  output logic rise_o,
  output logic fall_o,
  output logic lr_o,
  output logic din_o
);
  localparam int LAST = STAGES - 1;

  logic [2:0] pipe [STAGES];
  logic       bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      bclk_d <= 1'b0;
    end else begin
      pipe[0] <= {bclk_i, lrclk_i, sdin_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_d <= pipe[LAST][2];
    end
  end

  assign rise_o = pipe[LAST][2] & ~bclk_d;
  assign fall_o = ~pipe[LAST][2] & bclk_d;
  assign lr_o   = pipe[LAST][1];
  assign din_o  = pipe[LAST][0];
endmodule

// File: rtl/aud_slot_timer.sv
module aud_slot_timer
  import aud_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  fmt_e             fmt,
  input  logic             rise,
  input  logic             lr,
  output logic             chg,
  output logic [CNT_W-1:0] eff_cnt,
  output logic [CNT_W-1:0] eff_hlen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, hlen, inc;
  logic             lr_last;

  always_comb begin
    chg      = (fmt == FMT_DSP) ? (lr & ~lr_last) : (lr ^ lr_last);
    inc      = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    eff_cnt  = chg ? '0 : inc;
    eff_hlen = (chg && fmt != FMT_DSP) ? inc : hlen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_MAX;
      hlen    <= '0;
      lr_last <= 1'b0;
    end else if (!en) begin
      cnt     <= CNT_MAX;
      hlen    <= '0;
      lr_last <= lr;
    end else if (rise) begin
      cnt     <= eff_cnt;
      hlen    <= eff_hlen;
      lr_last <= lr;
    end
  end
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rise,
  input  slot_t               slot,
  input  logic [POS_W-1:0]    w,
  input  logic                din,
  input  logic                rx_ready,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right
);
  localparam logic [POS_W-1:0] SW = POS_W'(SAMPLE_W);

  logic [MAX_WORD-1:0] sh, sh_next;
  logic [SAMPLE_W-1:0] conv, hold;
  logic                take, done;

  always_comb begin
    sh_next = {sh[MAX_WORD-2:0], din};
    if (w == POS_W'(MAX_WORD)) conv = sh_next[MAX_WORD-1 -: SAMPLE_W];
    else                       conv = sh_next[SAMPLE_W-1:0] << (SW - w);
    take = rise && slot.active;
    done = take && (slot.pos == w - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      hold     <= '0;
      rx_valid <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
    end else if (!en) begin
      hold     <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (take) sh <= sh_next;
      if (done) begin
        if (!slot.right) begin
          hold <= conv;
        end else begin
          rx_left  <= hold;
          rx_right <= conv;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
  import aud_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                fall,
  input  slot_t               slot,
  input  logic                frame_start,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_ready,
  output logic                sdout,
  output logic                sdout_oe
);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [POS_W-1:0] TOP = POS_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] buf_l, buf_r, cur_l, cur_r, sh_l, sh_r, samp;
  logic [POS_W-1:0]    idx;
  logic                buf_full, load, bit_out;

  assign tx_ready = en & ~buf_full;

  always_comb begin
    load  = fall && frame_start;
    cur_l = sh_l;
    cur_r = sh_r;
    if (load) begin
      cur_l = buf_full ? buf_l : '0;
      cur_r = buf_full ? buf_r : '0;
    end
    samp    = slot.right ? cur_r : cur_l;
    idx     = TOP - slot.pos;
    bit_out = slot.active && (slot.pos <= TOP) && samp[idx[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_l    <= '0;
      buf_r    <= '0;
      buf_full <= 1'b0;
      sh_l     <= '0;
      sh_r     <= '0;
      sdout    <= 1'b0;
      sdout_oe <= 1'b0;
    end else if (!en) begin
      buf_full <= 1'b0;
      sh_l     <= '0;
      sh_r     <= '0;
      sdout    <= 1'b0;
      sdout_oe <= 1'b0;
    end else begin
      sdout_oe <= 1'b1;
      if (tx_valid && tx_ready) begin
        buf_l    <= tx_left;
        buf_r    <= tx_right;
        buf_full <= 1'b1;
      end
      if (load) begin
        sh_l <= cur_l;
        sh_r <= cur_r;
        if (buf_full) buf_full <= 1'b0;
      end
      if (fall) sdout <= bit_out;
    end
  end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic                dsp_late,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdin,
  output logic                sdout,
  output logic                sdout_oe,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right
);
  fmt_e             fmt_q;
  logic             rise_p, fall_p, lr_s, din_s, chg;
  logic [CNT_W-1:0] eff_cnt, eff_hlen;
  logic [POS_W-1:0] w;
  slot_t            slot;
  logic             frame_start;

  assign fmt_q = fmt_e'(fmt);
  assign w     = word_bits(fmt_q, wlen);

  aud_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdin_i(sdin),
    .rise_o(rise_p), .fall_o(fall_p), .lr_o(lr_s), .din_o(din_s)
  );

  aud_slot_timer timer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt_q), .rise(rise_p), .lr(lr_s),
    .chg(chg), .eff_cnt(eff_cnt), .eff_hlen(eff_hlen)
  );

  always_comb begin
    slot        = slot_decode(fmt_q, w, dsp_late, lr_s, eff_cnt, eff_hlen);
    frame_start = chg && !slot.right && (eff_cnt == '0);
  end

  aud_rx_deser rx_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(rise_p), .slot(slot), .w(w),
    .din(din_s), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right)
  );

  aud_tx_ser tx_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fall(fall_p), .slot(slot),
    .frame_start(frame_start), .tx_valid(tx_valid), .tx_left(tx_left),
    .tx_right(tx_right), .tx_ready(tx_ready), .sdout(sdout), .sdout_oe(sdout_oe)
  );
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sdout,
  input logic sdout_oe,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic rise_p,
  input logic fall_p
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sdout_oe && !sdout && !rx_valid));

  p_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> sdout_oe);

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready) |=> rx_valid);

  p_rx_from_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rise_p));

  p_tx_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sdout != $past(sdout)) && $past(en)) |-> $past(fall_p));
endmodule

bind aud_serial_port aud_serial_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .sdout(sdout), .sdout_oe(sdout_oe),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rise_p(rise_p), .fall_p(fall_p)
);

// File: tb/aud_serial_port_tb_top.sv
module aud_serial_port_tb_top;
  localparam int H = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, en, dsp_late, bclk, lrclk, sdin, sdout, sdout_oe;
  logic [1:0]  fmt, wlen;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [23:0] tx_left, tx_right, rx_left, rx_right;

  int errors = 0;
  int checks = 0;
  logic [31:0] cap_l, cap_r;
  int unused_bad;

  aud_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .wlen(wlen), .dsp_late(dsp_late),
    .bclk(bclk), .lrclk(lrclk), .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input int f, input int wl);
    if (wl == 0) return 16;
    if (wl == 1) return 20;
    if (wl == 2) return 24;
    return (f == 2) ? 24 : 32;
  endfunction

  function automatic logic [23:0] exp_rx(input logic [31:0] v, input int W);
    logic [31:0] t;
    if (W == 32) return v[31:8];
    t = v << (24 - W);
    return t[23:0];
  endfunction

  function automatic logic [31:0] exp_tx(input logic [23:0] c, input int W);
    if (W == 32) return {c, 8'h00};
    return {8'h00, c} >> (24 - W);
  endfunction

  task automatic slot_info(input int f, input int W, input int lt, input int k,
                           output bit lr, output bit act, output bit rt, output int p);
    int h, j, st;
    if (f == 3) begin
      lr  = (k == 0);
      p   = k - lt;
      rt  = (p >= W);
      if (rt) p = p - W;
      act = (k - lt >= 0) && (k - lt < 2 * W);
    end else begin
      h  = k / H;
      j  = k % H;
      rt = (h == 1);
      lr = (f == 0) ? rt : !rt;
      st = (f == 0) ? 1 : (f == 1) ? 0 : H - W;
      p  = j - st;
      act = (p >= 0) && (p < W);
    end
  endtask

  task automatic run_frame(input int f, input int W, input int lt,
                           input logic [31:0] wl_v, input logic [31:0] wr_v,
                           input bit do_push, input logic [23:0] pl, input logic [23:0] pr);
    bit lr, act, rt;
    int p;
    cap_l = 0;
    cap_r = 0;
    unused_bad = 0;
    for (int k = 0; k < 2 * H; k++) begin
      slot_info(f, W, lt, k, lr, act, rt, p);
      @(negedge clk);
      bclk  = 1'b0;
      lrclk = lr;
      sdin  = act ? (rt ? wr_v[W-1-p] : wl_v[W-1-p]) : 1'b1;
      if (do_push && k == 2) begin
        @(negedge clk);
        check(tx_ready === 1'b1, "R10 ready with empty buffer", {31'b0, tx_ready}, 1);
        tx_valid = 1'b1;
        tx_left  = pl;
        tx_right = pr;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready === 1'b0, "R10 ready drops when full", {31'b0, tx_ready}, 0);
        repeat (5) @(negedge clk);
      end else begin
        repeat (7) @(negedge clk);
      end
      if (act) begin
        if (rt) cap_r = {cap_r[30:0], sdout};
        else    cap_l = {cap_l[30:0], sdout};
      end else if (sdout !== 1'b0) begin
        unused_bad++;
      end
      @(negedge clk);
      bclk = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic run_config(input int f, input int wl, input int lt, input int seed);
    int W;
    string tg;
    logic [23:0] cl [4];
    logic [23:0] cr [4];
    logic [31:0] wlv, wrv, msk;
    W  = wbits(f, wl);
    tg = (f == 0) ? "R3" : (f == 1) ? "R4" : (f == 2) ? "R5" : "R6";
    msk = (W == 32) ? 32'hFFFF_FFFF : ((32'h1 << W) - 1);
    for (int i = 0; i < 4; i++) begin
      cl[i] = (i < 3) ? 24'(32'h9E37_79B9 * (seed * 8 + i * 2 + 1)) : 24'h0;
      cr[i] = (i < 3) ? 24'(32'h85EB_CA6B * (seed * 8 + i * 2 + 2)) : 24'h0;
    end
    @(negedge clk);
    en = 1'b0;
    fmt = 2'(f);
    wlen = 2'(wl);
    dsp_late = lt[0];
    bclk = 1'b1;
    lrclk = (f == 0) ? 1'b1 : 1'b0;
    repeat (6) @(negedge clk);
    check(sdout_oe === 1'b0 && sdout === 1'b0 && tx_ready === 1'b0 && rx_valid === 1'b0,
          "R1 idle while disabled", {28'b0, sdout_oe, sdout, tx_ready, rx_valid}, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(sdout_oe === 1'b1, "R1 output enabled", {31'b0, sdout_oe}, 1);
    tx_valid = 1'b1;
    tx_left  = cl[0];
    tx_right = cr[0];
    @(negedge clk);
    tx_valid = 1'b0;
    for (int fr = 0; fr < 4; fr++) begin
      wlv = (32'hC2B2_AE35 * (seed * 16 + fr * 2 + 1)) & msk;
      wrv = (32'h27D4_EB2F * (seed * 16 + fr * 2 + 2)) & msk;
      run_frame(f, W, lt, wlv, wrv, fr < 2, cl[fr+1 > 3 ? 3 : fr+1], cr[fr+1 > 3 ? 3 : fr+1]);
      if (fr >= 1) begin
        check(rx_valid === 1'b1, {tg, " R9 pair strobe"}, {31'b0, rx_valid}, 1);
        check(rx_left === exp_rx(wlv, W), {tg, " R2 R8 rx left"}, {8'b0, rx_left},
              {8'b0, exp_rx(wlv, W)});
        check(rx_right === exp_rx(wrv, W), {tg, " R2 R8 rx right"}, {8'b0, rx_right},
              {8'b0, exp_rx(wrv, W)});
        check(cap_l === exp_tx(cl[fr], W), {tg, (fr == 3) ? " R10 zero fill left" : " R7 tx left"},
              cap_l, exp_tx(cl[fr], W));
        check(cap_r === exp_tx(cr[fr], W), {tg, (fr == 3) ? " R10 zero fill right" : " R7 tx right"},
              cap_r, exp_tx(cr[fr], W));
        check(unused_bad == 0, {tg, " R7 unused slots zero"}, 32'(unused_bad), 0);
      end
      @(negedge clk);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      check(rx_valid === 1'b0, "R9 cleared by ready", {31'b0, rx_valid}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0; en = 1'b0; fmt = 2'd0; wlen = 2'd0; dsp_late = 1'b0;
    bclk = 1'b1; lrclk = 1'b0; sdin = 1'b0;
    tx_valid = 1'b0; tx_left = '0; tx_right = '0; rx_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(sdout_oe === 1'b0 && rx_valid === 1'b0 && tx_ready === 1'b0,
          "R1 reset state", {29'b0, sdout_oe, rx_valid, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    seed = 0;
    for (int f = 0; f < 4; f++) begin
      for (int wl = 0; wl < 4; wl++) begin
        for (int lt = 0; lt < ((f == 3) ? 2 : 1); lt++) begin
          seed++;
          run_config(f, wl, lt, seed);
        end
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule